// File: doc/BRIEF.md
# Per-Core Local Interrupt Router

This block gathers the interrupt sources that belong to each processor core into one pending word per core and drives one interrupt line per core. Each core has four generic-timer sources, one mailbox source, one fast GPU source and one performance-monitor source. Software enables the timer and mailbox sources per core. It routes the performance-monitor source through a per-core routing word, which has separate write-1-to-set and write-1-to-clear addresses. The per-core pending word can be read back.

The register port is a simple synchronous write strobe with an asynchronous (combinational) read. A write takes effect at the clock edge that samples it, and the pending word follows from then on without further delay. Besides the interrupt line, each core also gets the index of its lowest-numbered pending bit and a valid flag. The lowest bit is the one serviced first.

Top module: `core_irq_router`

## Requirements
- R1: After reset all enables and the routing word are zero. Every control register reads 0 and no core's interrupt line is driven by a timer, mailbox or performance-monitor source.
- R2: The timer enable register of core N is at byte address 0x40+4N, with bits 3:0 readable and the other bits reading 0. Enable bit k passes timer input k of that core (order: secure physical, non-secure physical, hypervisor physical, virtual) to pending bit k.
- R3: The mailbox enable register of core N is at 0x50+4N. Only bit 0 is stored, and the other bits read 0. Bit 0 passes that core's mailbox input to pending bit 4.
- R4: The fast GPU input of a core appears at pending bit 8 with no enable.
- R5: A write to 0x10 sets the routing bit of every core N whose data bit N is 1. Data bits that are 0 leave the routing word unchanged.
- R6: A write to 0x14 clears the routing bit of every core N whose data bit N is 1. Both 0x10 and 0x14 read back the routing word in bits NUM_CORES-1:0.
- R7: A core's performance-monitor input appears at pending bit 9 only while that core's routing bit is set.
- R8: The pending word of core N reads at 0x60+4N. Bits other than 0-4, 8 and 9 read 0, and writes to these addresses change nothing.
- R9: A core's interrupt output is high exactly when its pending word is nonzero.
- R10: Each core outputs the 4-bit index of its lowest set pending bit, and a valid flag that is high when any bit is pending.
- R11: Accesses to any other address read 0, and writes to them change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for reg_addr |
| timer_irq | input | 4*NUM_CORES | Timer sources, 4 per core, core N at bits 4N+3:4N |
| mbox_irq | input | NUM_CORES | Mailbox-0 interrupt per core |
| gpu_fast_irq | input | NUM_CORES | Fast GPU interrupt per core |
| pmu_irq | input | NUM_CORES | Performance-monitor interrupt per core |
| core_irq | output | NUM_CORES | Interrupt line per core |
| core_top_idx | output | 4*NUM_CORES | Lowest pending bit index per core |
| core_top_vld | output | NUM_CORES | Index valid per core |

## Verification
The bench drives mixes of sources in which several bits are pending together, such as GPU with performance monitor, or timer 3 with mailbox and performance monitor. A priority encoder that scans from the top, or that drops a bit, reports the wrong index. Enabling a single timer bit on a core that is not core 0 catches a reversed timer order and a wrong register stride. Writing zeros to the set address and clearing a single bit catch a routing register that is overwritten instead of modified bit by bit. Writes to the pending address and to unused addresses catch decoding that alters control state by aliasing.

// File: rtl/cir_pkg.sv
package cir_pkg;
  localparam int PEND_W = 16;
  localparam int IDX_W  = 4;
  localparam int TMR_N  = 4;
  localparam int MBX_BIT = 4;
  localparam int GPU_BIT = 8;
  localparam int PMU_BIT = 9;
  localparam logic [PEND_W-1:0] PEND_MAP = 16'h031F;

  localparam logic [7:0] OFS_PMU_SET = 8'h10;
  localparam logic [7:0] OFS_PMU_CLR = 8'h14;
  localparam logic [7:0] OFS_TMR     = 8'h40;
  localparam logic [7:0] OFS_MBX     = 8'h50;
  localparam logic [7:0] OFS_PEND    = 8'h60;

  typedef struct packed {
    logic             vld;
    logic [IDX_W-1:0] idx;
  } pick_t;

  // Scan downward so the last hit kept is the lowest set bit.
  function automatic pick_t lowest_pick(input logic [PEND_W-1:0] v);
    pick_t p;
    p = '0;
    for (int i = PEND_W - 1; i >= 0; i--) begin
      if (v[i]) begin
        p.vld = 1'b1;
        p.idx = IDX_W'(i);
      end
    end
    return p;
  endfunction
endpackage

// File: rtl/cir_regs.sv
module cir_regs
  import cir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [NUM_CORES*TMR_N-1:0] tmr_en,
  output logic [NUM_CORES-1:0]       mbx_en,
  output logic [NUM_CORES-1:0]       pmu_route,
  output logic [31:0]                ctl_rdata
);
  logic hit_set, hit_clr;
  logic [NUM_CORES-1:0] hit_tmr, hit_mbx;
  logic [31:0] core_rd [NUM_CORES];

  assign hit_set = reg_addr == ADDR_W'(OFS_PMU_SET);
  assign hit_clr = reg_addr == ADDR_W'(OFS_PMU_CLR);

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    assign hit_tmr[c] = reg_addr == ADDR_W'(OFS_TMR + 4 * c);
    assign hit_mbx[c] = reg_addr == ADDR_W'(OFS_MBX + 4 * c);

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        tmr_en[c*TMR_N +: TMR_N] <= '0;
        mbx_en[c]                <= 1'b0;
      end else if (reg_wr) begin
        if (hit_tmr[c]) tmr_en[c*TMR_N +: TMR_N] <= reg_wdata[TMR_N-1:0];
        if (hit_mbx[c]) mbx_en[c] <= reg_wdata[0];
      end
    end

    always_comb begin
      core_rd[c] = '0;
      if (hit_tmr[c]) core_rd[c][TMR_N-1:0] = tmr_en[c*TMR_N +: TMR_N];
      if (hit_mbx[c]) core_rd[c][0] = mbx_en[c];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pmu_route <= '0;
    end else if (reg_wr && hit_set) begin
      pmu_route <= pmu_route | reg_wdata[NUM_CORES-1:0];
    end else if (reg_wr && hit_clr) begin
      pmu_route <= pmu_route & ~reg_wdata[NUM_CORES-1:0];
    end
  end

  always_comb begin
    ctl_rdata = '0;
    if (hit_set || hit_clr) ctl_rdata[NUM_CORES-1:0] = pmu_route;
    for (int c = 0; c < NUM_CORES; c++) ctl_rdata = ctl_rdata | core_rd[c];
  end
endmodule

// File: rtl/cir_core_pend.sv
module cir_core_pend
  import cir_pkg::*;
(
  input  logic [TMR_N-1:0]  tmr_src,
  input  logic [TMR_N-1:0]  tmr_en,
  input  logic              mbx_src,
  input  logic              mbx_en,
  input  logic              gpu_src,
  input  logic              pmu_src,
  input  logic              pmu_en,
  output logic [PEND_W-1:0] pend,
  output logic              irq,
  output logic [IDX_W-1:0]  top_idx,
  output logic              top_vld
);
  pick_t pick;

  always_comb begin
    pend = '0;
    pend[TMR_N-1:0] = tmr_src & tmr_en;
    pend[MBX_BIT]   = mbx_src & mbx_en;
    pend[GPU_BIT]   = gpu_src;
    pend[PMU_BIT]   = pmu_src & pmu_en;
  end

  assign irq     = |pend;
  assign pick    = lowest_pick(pend);
  assign top_idx = pick.idx;
  assign top_vld = pick.vld;
endmodule

// File: rtl/core_irq_router.sv
module core_irq_router
  import cir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       reg_wr,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [31:0]                reg_wdata,
  output logic [31:0]                reg_rdata,
  input  logic [NUM_CORES*TMR_N-1:0] timer_irq,
  input  logic [NUM_CORES-1:0]       mbox_irq,
  input  logic [NUM_CORES-1:0]       gpu_fast_irq,
  input  logic [NUM_CORES-1:0]       pmu_irq,
  output logic [NUM_CORES-1:0]       core_irq,
  output logic [NUM_CORES*IDX_W-1:0] core_top_idx,
  output logic [NUM_CORES-1:0]       core_top_vld
);
  logic [NUM_CORES*TMR_N-1:0]  tmr_en_w;
  logic [NUM_CORES-1:0]        mbx_en_w;
  logic [NUM_CORES-1:0]        pmu_route_w;
  logic [31:0]                 ctl_rdata;
  logic [NUM_CORES*PEND_W-1:0] pend_flat;

  cir_regs #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .tmr_en(tmr_en_w), .mbx_en(mbx_en_w),
    .pmu_route(pmu_route_w), .ctl_rdata(ctl_rdata)
  );

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_core
    cir_core_pend u_pend (
      .tmr_src(timer_irq[c*TMR_N +: TMR_N]),
      .tmr_en(tmr_en_w[c*TMR_N +: TMR_N]),
      .mbx_src(mbox_irq[c]), .mbx_en(mbx_en_w[c]),
      .gpu_src(gpu_fast_irq[c]),
      .pmu_src(pmu_irq[c]), .pmu_en(pmu_route_w[c]),
      .pend(pend_flat[c*PEND_W +: PEND_W]),
      .irq(core_irq[c]),
      .top_idx(core_top_idx[c*IDX_W +: IDX_W]),
      .top_vld(core_top_vld[c])
    );
  end

  always_comb begin
    reg_rdata = ctl_rdata;
    for (int c = 0; c < NUM_CORES; c++) begin
      if (reg_addr == ADDR_W'(OFS_PEND + 4 * c))
        reg_rdata = 32'(pend_flat[c*PEND_W +: PEND_W]);
    end
  end
endmodule

// File: rtl/cir_checker.sv
module cir_checker
  import cir_pkg::*;
#(
  parameter int NUM_CORES = 4,
  parameter int ADDR_W    = 8
) (
  input logic                       clk,
  input logic                       rst_n,
  input logic                       reg_wr,
  input logic [ADDR_W-1:0]          reg_addr,
  input logic [31:0]                reg_wdata,
  input logic [NUM_CORES*TMR_N-1:0] tmr_en_w,
  input logic [NUM_CORES-1:0]       pmu_route_w,
  input logic [NUM_CORES*PEND_W-1:0] pend_flat,
  input logic [NUM_CORES-1:0]       core_irq,
  input logic [NUM_CORES*IDX_W-1:0] core_top_idx,
  input logic [NUM_CORES-1:0]       core_top_vld
);
  p_route_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_PMU_SET)) |=>
      pmu_route_w == ($past(pmu_route_w) | $past(reg_wdata[NUM_CORES-1:0])));

  p_route_clr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_addr == ADDR_W'(OFS_PMU_CLR)) |=>
      pmu_route_w == ($past(pmu_route_w) & ~$past(reg_wdata[NUM_CORES-1:0])));

  p_route_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && (reg_addr == ADDR_W'(OFS_PMU_SET) || reg_addr == ADDR_W'(OFS_PMU_CLR)))
      |=> $stable(pmu_route_w));

  for (genvar c = 0; c < NUM_CORES; c++) begin : g_chk
    for (genvar k = 0; k < TMR_N; k++) begin : g_tmr
      p_timer_gate_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !tmr_en_w[c*TMR_N+k] |-> !pend_flat[c*PEND_W+k]);
    end

    p_pmu_gate_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !pmu_route_w[c] |-> !pend_flat[c*PEND_W+PMU_BIT]);

    p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (pend_flat[c*PEND_W +: PEND_W] & ~PEND_MAP) == '0);

    p_irq_vld_r9: assert property (@(posedge clk) disable iff (!rst_n)
      core_irq[c] == core_top_vld[c]);

    p_idx_lowest_r10: assert property (@(posedge clk) disable iff (!rst_n)
      core_top_vld[c] |->
        (pend_flat[c*PEND_W + core_top_idx[c*IDX_W +: IDX_W]] &&
         ((pend_flat[c*PEND_W +: PEND_W] &
           ((PEND_W'(1) << core_top_idx[c*IDX_W +: IDX_W]) - PEND_W'(1))) == '0)));
  end
endmodule

bind core_irq_router cir_checker #(.NUM_CORES(NUM_CORES), .ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .tmr_en_w(tmr_en_w), .pmu_route_w(pmu_route_w),
  .pend_flat(pend_flat), .core_irq(core_irq), .core_top_idx(core_top_idx),
  .core_top_vld(core_top_vld)
);

// File: tb/test_core_irq_router.sv
module test_core_irq_router;
  localparam int NC = 4;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NC*4-1:0] timer_irq = '0;
  logic [NC-1:0] mbox_irq = '0, gpu_fast_irq = '0, pmu_irq = '0;
  logic [NC-1:0] core_irq, core_top_vld;
  logic [NC*4-1:0] core_top_idx;

  int nchk = 0, nerr = 0;
  logic [31:0] rv;

  core_irq_router #(.NUM_CORES(NC), .ADDR_W(8)) i_core_irq_router (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .timer_irq(timer_irq),
    .mbox_irq(mbox_irq), .gpu_fast_irq(gpu_fast_irq), .pmu_irq(pmu_irq),
    .core_irq(core_irq), .core_top_idx(core_top_idx), .core_top_vld(core_top_vld)
  );

  always #10 clk = ~clk;

  // {pmu, gpu, mbox, timer[3:0]} for core 0, expected pending word, expected index
  localparam logic [20:0] VEC [9] = '{
    {7'b0000000, 10'h000, 4'd0},
    {7'b0000001, 10'h001, 4'd0},
    {7'b0001100, 10'h00C, 4'd2},
    {7'b0010000, 10'h010, 4'd4},
    {7'b0100000, 10'h100, 4'd8},
    {7'b1000000, 10'h200, 4'd9},
    {7'b1100000, 10'h300, 4'd8},
    {7'b1111111, 10'h31F, 4'd0},
    {7'b1011000, 10'h218, 4'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  initial begin
    #(20 * 100000);
    nerr++;
    $display("FAIL watchdog actual=running expected=done");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    rd(8'h40, rv); chk("R1 timer en reset", rv, 0);
    rd(8'h5C, rv); chk("R1 mbox en reset", rv, 0);
    rd(8'h10, rv); chk("R1 routing reset", rv, 0);
    timer_irq = '1; mbox_irq = '1; pmu_irq = '1;
    #1 chk("R1 no irq with all gated", 32'(core_irq), 0);
    timer_irq = '0; mbox_irq = '0; pmu_irq = '0;

    // Table: core 0 fully enabled
    wr(8'h40, 32'hF);
    wr(8'h50, 32'h1);
    wr(8'h10, 32'h1);
    foreach (VEC[i]) begin
      @(negedge clk);
      timer_irq[3:0] = VEC[i][17:14];
      mbox_irq[0]    = VEC[i][18];
      gpu_fast_irq[0] = VEC[i][19];
      pmu_irq[0]     = VEC[i][20];
      reg_addr = 8'h60;
      #1;
      chk("R2/R3/R4/R7/R8 pending word", reg_rdata, 32'(VEC[i][13:4]));
      chk("R9 irq line", 32'(core_irq[0]), 32'(VEC[i][13:4] != 0));
      chk("R10 valid", 32'(core_top_vld[0]), 32'(VEC[i][13:4] != 0));
      if (VEC[i][13:4] != 0) chk("R10 lowest index", 32'(core_top_idx[3:0]), 32'(VEC[i][3:0]));
    end
    timer_irq = '0; mbox_irq = '0; gpu_fast_irq = '0; pmu_irq = '0;

    // R2: core 2 enable only non-secure physical (bit 1), stride 0x48
    wr(8'h48, 32'hFFFF_FFF2);
    rd(8'h48, rv); chk("R2 timer reg readback width", rv, 32'h2);
    timer_irq[11:8] = 4'hF;
    rd(8'h68, rv); chk("R2 only timer 1 on core2", rv, 32'h002);
    chk("R10 core2 index", 32'(core_top_idx[11:8]), 1);
    chk("R2 core1 untouched", 32'(core_irq[1]), 0);
    timer_irq[11:8] = 4'b1101;
    rd(8'h68, rv); chk("R2 other timers gated", rv, 0);
    chk("R9 core2 line low", 32'(core_irq[2]), 0);
    timer_irq = '0;
    wr(8'h4C, 32'h8);
    timer_irq[15:12] = 4'h8;
    rd(8'h6C, rv); chk("R2 core3 virtual timer", rv, 32'h008);
    timer_irq = '0;

    // R3: mailbox register only keeps bit 0
    wr(8'h5C, 32'hFFFF_FFFF);
    rd(8'h5C, rv); chk("R3 mbox readback", rv, 1);
    mbox_irq[3] = 1'b1;
    rd(8'h6C, rv); chk("R3 core3 mailbox pending", rv, 32'h010);
    chk("R10 core3 index", 32'(core_top_idx[15:12]), 4);
    mbox_irq = '0;

    // R5/R6/R7: routing word, currently 0001
    wr(8'h10, 32'h4);
    rd(8'h10, rv); chk("R5 set adds core2", rv, 32'h5);
    wr(8'h10, 32'h0);
    rd(8'h10, rv); chk("R5 zero write no effect", rv, 32'h5);
    wr(8'h14, 32'h1);
    rd(8'h14, rv); chk("R6 clear core0 via clr addr", rv, 32'h4);
    wr(8'h14, 32'h0);
    rd(8'h10, rv); chk("R6 zero clear no effect", rv, 32'h4);
    pmu_irq = '1;
    rd(8'h68, rv); chk("R7 core2 routed", rv, 32'h200);
    rd(8'h64, rv); chk("R7 core1 not routed", rv, 0);
    rd(8'h60, rv); chk("R7 core0 cleared", rv, 0);
    pmu_irq = '0;

    // R8: writes to pending ignored
    wr(8'h60, 32'hFFFF_FFFF);
    rd(8'h60, rv); chk("R8 pending write ignored", rv, 0);
    chk("R8 no irq after pending write", 32'(core_irq[0]), 0);
    rd(8'h40, rv); chk("R8 timer en untouched", rv, 32'hF);

    // R11: unmapped address
    wr(8'h30, 32'hFFFF_FFFF);
    rd(8'h30, rv); chk("R11 unmapped reads zero", rv, 0);
    rd(8'h10, rv); chk("R11 routing untouched", rv, 32'h4);
    rd(8'h44, rv); chk("R11 core1 timer untouched", rv, 0);

    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule